// File: doc/BRIEF.md
# Sector-Rotated Rectifier Gate Generator

This block drives the six bidirectional switches of the input stage of a rectifier that has no DC-link capacitor. Each switch ties one of the three input phases to the upper or the lower rail. The block takes three inputs. The first is a 3-bit input-current sector. The second is a compare word that sets the duty of the first active current vector. The third is the count of a shared up/down carrier counter, which forms a symmetric triangle. From these it assigns each switch one of four roles. One switch is pinned on for the whole period. One switch is on while the carrier is below the compare word. One switch is the exact complement of that compared switch. The remaining three switches are held off. Zero current vectors are never produced, so the compared switch and its complement together always fill the whole period.

The role assignment rotates with the sector. In odd sectors an upper switch is pinned and two lower switches are modulated. In even sectors a lower switch is pinned and two upper switches are modulated. The sector and the compare word are double-buffered. They are taken only at the sample where the carrier count is zero, so a change partway through a period never disturbs the gates. Sector codes 0 and 7 are invalid and turn every gate off.

Top module: `rect_gate_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first sample with a carrier count of zero, all six gates are low.
- R2: The sector and compare inputs are captured only on a clock edge where `cntIn` is zero. Changes at any other time have no effect on the gates until the next such edge.
- R3: Gate bits are numbered 0..2 for the upper switches of phases a, b and c (`gateUp[0..2]`) and 3..5 for the lower switches (`gateDn[0..2]`). For each sector the pinned, compared and complementary switches are: sector 1: up-a, dn-b, dn-c. Sector 2: dn-c, up-a, up-b. Sector 3: up-b, dn-c, dn-a. Sector 4: dn-a, up-b, up-c. Sector 5: up-c, dn-a, dn-b. Sector 6: dn-b, up-c, up-a. The pinned switch is high on every sample of the period.
- R4: The compared switch is high on each sample where the count is below the captured compare word. With the carrier sequence 0,1,..,M,M-1,..,1 (2M samples), it is high for 0 samples if the word is 0, for 2·word−1 samples if 1 ≤ word ≤ M, and for all 2M samples if the word exceeds M.
- R5: The complementary switch is the exact inverse of the compared switch on every sample, so their on-counts sum to 2M.
- R6: In a valid sector the other three switches are low on every sample, so exactly one upper and one lower gate are high at any time.
- R7: A captured sector code of 0 or 7 forces all six gates low for the whole period.
- R8: The gates are registered. The value visible after a clock edge reflects the count sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sectorIn | input | 3 | Input-current sector, 1..6 valid |
| cmpIn | input | CNT_W | Compare word for the first active vector |
| cntIn | input | CNT_W | Shared up/down carrier count |
| gateUp | output | 3 | Upper switch gates, phases a, b, c |
| gateDn | output | 3 | Lower switch gates, phases a, b, c |

## Verification
The bench builds the block with the default 8-bit count width and drives a triangle peaking at 100. At that peak a compare word from 101 to 255 lies above the carrier top, so the saturated full-on case is reachable alongside zero, one and the exact peak. A 200-sample period keeps about forty periods within a short run. The sector and compare word are changed at a random sample inside each period, so every period exercises the capture-at-zero rule. Both invalid codes appear in the directed set.

// File: rtl/rgg_pkg.sv
package rgg_pkg;
  localparam int PHASES = 3;

  typedef struct packed {
    logic       load;       // carrier at zero: capture new inputs
    logic       valid;      // effective sector is 1..6
    logic [1:0] heldPhase;  // phase whose switch is pinned on
    logic       heldUpper;  // pinned switch is on the upper rail
  } rggStrobe_t;
endpackage

// File: rtl/rgg_ctrl.sv
module rgg_ctrl
  import rgg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       sectorIn,
  input  logic [CNT_W-1:0] cntIn,
  output rggStrobe_t       strb
);
  logic [2:0] sectorQ;
  logic [2:0] effSector;
  logic       load;

  assign load      = (cntIn == '0);
  assign effSector = load ? sectorIn : sectorQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sectorQ <= 3'd0;
    else if (load) sectorQ <= sectorIn;
  end

  always_comb begin
    strb.load      = load;
    strb.valid     = 1'b1;
    strb.heldPhase = 2'd0;
    strb.heldUpper = 1'b1;
    unique case (effSector)
      3'd1: begin strb.heldPhase = 2'd0; strb.heldUpper = 1'b1; end
      3'd2: begin strb.heldPhase = 2'd2; strb.heldUpper = 1'b0; end
      3'd3: begin strb.heldPhase = 2'd1; strb.heldUpper = 1'b1; end
      3'd4: begin strb.heldPhase = 2'd0; strb.heldUpper = 1'b0; end
      3'd5: begin strb.heldPhase = 2'd2; strb.heldUpper = 1'b1; end
      3'd6: begin strb.heldPhase = 2'd1; strb.heldUpper = 1'b0; end
      default: strb.valid = 1'b0;
    endcase
  end

  // R2: the role strobes only move across a capture edge
  a_r2_roles_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !$past(load)) |-> $stable({strb.valid, strb.heldPhase, strb.heldUpper}));
endmodule

// File: rtl/rgg_datapath.sv
module rgg_datapath
  import rgg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rggStrobe_t       strb,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic [CNT_W-1:0] cntIn,
  output logic [PHASES-1:0] gateUp,
  output logic [PHASES-1:0] gateDn
);
  logic [CNT_W-1:0]  cmpQ;
  logic [CNT_W-1:0]  cmpEff;
  logic              cmpOn;
  logic [1:0]        cmpPhase;
  logic [1:0]        cplPhase;
  logic [PHASES-1:0] upNext;
  logic [PHASES-1:0] dnNext;

  assign cmpEff   = strb.load ? cmpIn : cmpQ;
  assign cmpOn    = (cntIn < cmpEff);
  assign cmpPhase = (strb.heldPhase == 2'd2) ? 2'd0 : strb.heldPhase + 2'd1;
  assign cplPhase = (cmpPhase == 2'd2) ? 2'd0 : cmpPhase + 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cmpQ <= '0;
    else if (strb.load) cmpQ <= cmpIn;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic isHeld, isCmp, isCpl, modOn;
    assign isHeld = (strb.heldPhase == 2'(p));
    assign isCmp  = (cmpPhase == 2'(p));
    assign isCpl  = (cplPhase == 2'(p));
    assign modOn  = (isCmp & cmpOn) | (isCpl & ~cmpOn);
    assign upNext[p] = strb.valid & (strb.heldUpper ? isHeld : modOn);
    assign dnNext[p] = strb.valid & (strb.heldUpper ? modOn : isHeld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateUp <= '0;
      gateDn <= '0;
    end else begin
      gateUp <= upNext;
      gateDn <= dnNext;
    end
  end

  // R1: gates are cleared by reset
  a_r1_reset_off: assert property (@(posedge clk)
    !rstN |=> (gateUp == '0 && gateDn == '0));

  // R7: an invalid sector turns every gate off
  a_r7_invalid_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.valid |=> (gateUp == '0 && gateDn == '0));

  // R6: in a valid sector exactly one gate per rail is on
  a_r6_one_per_side: assert property (@(posedge clk) disable iff (!rstN)
    strb.valid |=> ($countones(gateUp) == 1 && $countones(gateDn) == 1));
endmodule

// File: rtl/rect_gate_gen.sv
module rect_gate_gen
  import rgg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       sectorIn,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic [CNT_W-1:0] cntIn,
  output logic [2:0]       gateUp,
  output logic [2:0]       gateDn
);
  rggStrobe_t strb;

  rgg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sectorIn (sectorIn),
    .cntIn    (cntIn),
    .strb     (strb)
  );

  rgg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cmpIn  (cmpIn),
    .cntIn  (cntIn),
    .gateUp (gateUp),
    .gateDn (gateDn)
  );
endmodule

// File: tb/rect_gate_gen_bench.sv
module rect_gate_gen_bench;
  localparam int CNT_W = 8;
  localparam int CMAX  = 100;
  localparam int PER   = 2 * CMAX;
  localparam int NPER  = 40;

  logic             clk = 1'b0;
  logic             rstN;
  logic [2:0]       sectorIn;
  logic [CNT_W-1:0] cmpIn;
  logic [CNT_W-1:0] cntIn;
  logic [2:0]       gateUp;
  logic [2:0]       gateDn;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  rect_gate_gen #(.CNT_W(CNT_W)) u_rect_gate_gen (
    .clk(clk), .rstN(rstN), .sectorIn(sectorIn), .cmpIn(cmpIn),
    .cntIn(cntIn), .gateUp(gateUp), .gateDn(gateDn)
  );

  always #4 clk = ~clk;

  function automatic int triCnt(int i);
    return (i <= CMAX) ? i : PER - i;
  endfunction

  // role table from R3: returns {held, cmp, cpl} gate indices
  function automatic void roles(input int sec, output int h, output int c, output int k);
    case (sec)
      1: begin h = 0; c = 4; k = 5; end
      2: begin h = 5; c = 0; k = 1; end
      3: begin h = 1; c = 5; k = 3; end
      4: begin h = 3; c = 1; k = 2; end
      5: begin h = 2; c = 3; k = 4; end
      6: begin h = 4; c = 2; k = 0; end
      default: begin h = -1; c = -1; k = -1; end
    endcase
  endfunction

  function automatic logic [5:0] expGates(int sec, int cmp, int cnt);
    int h, c, k;
    logic [5:0] g = '0;
    roles(sec, h, c, k);
    if (h >= 0) begin
      g[h] = 1'b1;
      g[c] = (cnt < cmp);
      g[k] = !(cnt < cmp);
    end
    return g;
  endfunction

  function automatic int expOnCnt(int cmp);
    if (cmp == 0) return 0;
    if (cmp <= CMAX) return 2 * cmp - 1;
    return PER;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // bench state
  int planSec[NPER+1];
  int planCmp[NPER+1];
  int shSec, shCmp;
  bit havePrev = 0;
  int prevSec, prevCmp, prevCnt, prevIdx;
  int onCnt[6];
  int misCnt;
  int misAct, misExp;

  task automatic sampleCheck();
    logic [5:0] act, exp;
    int h, c, k, others;
    act = {gateDn, gateUp};
    exp = expGates(prevSec, prevCmp, prevCnt);
    if (act != exp) begin
      if (misCnt == 0) begin misAct = int'(act); misExp = int'(exp); end
      misCnt++;
    end
    for (int b = 0; b < 6; b++) onCnt[b] += int'(act[b]);
    if (prevIdx == PER - 1) begin
      // per-sample agreement, with inputs moved mid-period (R2, R8)
      check(misCnt == 0, "R2 R8 sample gates", misAct, misExp);
      roles(prevSec, h, c, k);
      if (h < 0) begin
        others = 0;
        for (int b = 0; b < 6; b++) others += onCnt[b];
        check(others == 0, "R7 invalid sector on-count", others, 0);
      end else begin
        check(onCnt[h] == PER, "R3 pinned switch on-count", onCnt[h], PER);
        check(onCnt[c] == expOnCnt(prevCmp), "R4 compared on-count", onCnt[c], expOnCnt(prevCmp));
        check(onCnt[c] + onCnt[k] == PER && onCnt[k] == PER - expOnCnt(prevCmp),
              "R5 complement on-count", onCnt[k], PER - expOnCnt(prevCmp));
        others = 0;
        for (int b = 0; b < 6; b++) if (b != h && b != c && b != k) others += onCnt[b];
        check(others == 0, "R6 unused switches on-count", others, 0);
      end
      for (int b = 0; b < 6; b++) onCnt[b] = 0;
      misCnt = 0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // directed corners first: mid, zero, peak, one, saturated, then invalid codes
    planSec[0] = 1; planCmp[0] = 50;
    planSec[1] = 2; planCmp[1] = 0;
    planSec[2] = 3; planCmp[2] = CMAX;
    planSec[3] = 4; planCmp[3] = 1;
    planSec[4] = 5; planCmp[4] = 255;
    planSec[5] = 6; planCmp[5] = 30;
    planSec[6] = 0; planCmp[6] = 40;
    planSec[7] = 7; planCmp[7] = 60;
    for (int p = 8; p <= NPER; p++) begin
      planSec[p] = int'($urandom % 8);
      planCmp[p] = int'($urandom % (CMAX + 20));
    end
    for (int b = 0; b < 6; b++) onCnt[b] = 0;
    misCnt = 0; misAct = 0; misExp = 0;

    rstN = 1'b0; sectorIn = 3'd0; cmpIn = '0; cntIn = '0;
    repeat (3) @(negedge clk);
    check({gateDn, gateUp} == 6'd0, "R1 gates in reset", int'({gateDn, gateUp}), 0);

    // release reset with nonzero count: nothing is captured yet
    sectorIn = 3'd1; cmpIn = 8'd50; cntIn = 8'd5;
    rstN = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check({gateDn, gateUp} == 6'd0, "R1 gates before first capture", int'({gateDn, gateUp}), 0);
    end
    sectorIn = 3'(planSec[0]); cmpIn = CNT_W'(planCmp[0]);

    for (int p = 0; p < NPER; p++) begin
      int chgAt = 1 + int'($urandom % (PER - 1));
      for (int i = 0; i < PER; i++) begin
        @(negedge clk);
        if (havePrev) sampleCheck();
        cntIn = CNT_W'(triCnt(i));
        if (i == 0) begin shSec = int'(sectorIn); shCmp = int'(cmpIn); end
        if (i == chgAt) begin
          sectorIn = 3'(planSec[p+1]);
          cmpIn    = CNT_W'(planCmp[p+1]);
        end
        prevSec = shSec; prevCmp = shCmp; prevCnt = triCnt(i); prevIdx = i;
        havePrev = 1;
      end
    end
    @(negedge clk);
    sampleCheck();
    done = 1;
    finishRun();
  end
endmodule